// File: doc/BRIEF.md
# Palette Colour Byte-Pair Writer

This block lets a byte-wide host bus load a 256-entry palette of 15-bit colours into a palette storage array. Each colour holds three 5-bit channels: red in bits 4:0, green in bits 9:5 and blue in bits 14:10. The host first loads an 8-bit entry pointer. It then sends bytes on a data strobe. A phase flag sends each byte alternately to the low half and the high half of the current colour.

A low-half byte is only held in a staging register. When the high-half byte arrives, the block drops that byte's top bit and joins the remaining seven bits to the staged low byte. It then presents the finished 15-bit colour, with its entry number and a one-cycle write enable, to the palette storage. The pointer then moves to the next entry and wraps from 255 to 0, so a stream of byte pairs fills consecutive entries. Loading the pointer always returns the phase to the low half.

Top module: `pal_byte_writer`

## Requirements
- R1: After reset, the storage write enable, entry number and colour outputs are all zero, the pointer is 0, and the phase is low, so the first two data bytes with no pointer load go to entry 0.
- R2: A data byte taken in the low phase raises no storage write and moves the phase to high.
- R3: A data byte taken in the high phase raises the storage write enable in the following cycle. The entry number is the pointer as it was before that byte, and the colour is {high byte bits 6:0, staged low byte}, so red = colour[4:0], green = colour[9:5] and blue = colour[14:10].
- R4: Bit 7 of a high-phase byte never reaches the stored colour: bytes 0xFF, 0xFF store 0x7FFF.
- R5: The pointer advances by one only after a high-phase byte, and it wraps from 255 to 0.
- R6: Loading the pointer sets the phase to low and discards any staged low byte. The next two data bytes then form the colour for the newly loaded entry.
- R7: When a pointer load and a data byte arrive in the same cycle, the pointer load wins, the data byte is dropped, and no storage write follows.
- R8: The write enable lasts exactly one cycle for each completed pair, even when pairs are sent with no idle cycles between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ptr_we | input | 1 | Load strobe for the entry pointer |
| ptr_data | input | 8 | New pointer value |
| byte_we | input | 1 | Data byte strobe |
| byte_data | input | 8 | Data byte |
| pal_we | output | 1 | One-cycle write enable toward palette storage |
| pal_idx | output | 8 | Entry number to be written |
| pal_val | output | 15 | Colour to be written (blue, green, red, 5 bits each) |

## Verification
A pointer load and a data byte can arrive in the same cycle. The outcome depends on the phase, because the dropped byte could either overwrite the staged low byte or complete a pair. The bench causes both cases: once with a low byte already staged and once in the low phase. Each is followed by a fresh byte pair. The scoreboard confirms that no write appeared in between and that the next commit lands on the newly loaded entry and holds only the fresh pair's bytes.

// File: rtl/pal_wr_pkg.sv
package pal_wr_pkg;
  localparam int unsigned CH_W    = 5;
  localparam int unsigned N_CH    = 3;
  localparam int unsigned COLOR_W = CH_W * N_CH;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned HI_W    = COLOR_W - BYTE_W;
  localparam int unsigned IDX_W   = 8;

  typedef struct packed {
    logic [CH_W-1:0] blue;
    logic [CH_W-1:0] green;
    logic [CH_W-1:0] red;
  } color_t;
endpackage

// File: rtl/pal_phase_ctl.sv
module pal_phase_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic ptr_we,
  input  logic byte_we,
  output logic phase_hi,
  output logic lo_cap,
  output logic hi_commit
);
  logic phase_d;
  logic phase_en;

  // A pointer load takes precedence over a data byte in the same cycle.
  always_comb begin
    lo_cap    = byte_we & ~ptr_we & ~phase_hi;
    hi_commit = byte_we & ~ptr_we &  phase_hi;
    phase_en  = ptr_we | byte_we;
    if (ptr_we) begin
      phase_d = 1'b0;
    end else begin
      phase_d = ~phase_hi;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_hi <= 1'b0;
    end else if (phase_en) begin
      phase_hi <= phase_d;
    end
  end
endmodule

// File: rtl/pal_idx_ctr.sv
module pal_idx_ctr #(
  parameter int unsigned IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [IDX_W-1:0] load_val,
  input  logic             step,
  output logic [IDX_W-1:0] idx
);
  logic [IDX_W-1:0] idx_d;
  logic             idx_en;

  always_comb begin
    idx_en = load | step;
    if (load) begin
      idx_d = load_val;
    end else begin
      idx_d = idx + IDX_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx <= '0;
    end else if (idx_en) begin
      idx <= idx_d;
    end
  end
endmodule

// File: rtl/pal_commit_reg.sv
module pal_commit_reg
  import pal_wr_pkg::*;
#(
  parameter int unsigned IDX_W = pal_wr_pkg::IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lo_cap,
  input  logic              hi_commit,
  input  logic [BYTE_W-1:0] byte_data,
  input  logic [IDX_W-1:0]  cur_idx,
  output logic              pal_we,
  output logic [IDX_W-1:0]  pal_idx,
  output color_t            pal_val
);
  logic [BYTE_W-1:0] lo_q;
  color_t            val_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
    end else if (lo_cap) begin
      lo_q <= byte_data;
    end
  end

  // The top bit of the high byte is dropped; the colour is exactly HI_W + BYTE_W wide.
  always_comb begin
    val_d = color_t'({byte_data[HI_W-1:0], lo_q});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pal_we <= 1'b0;
    end else begin
      pal_we <= hi_commit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pal_idx <= '0;
      pal_val <= '0;
    end else if (hi_commit) begin
      pal_idx <= cur_idx;
      pal_val <= val_d;
    end
  end
endmodule

// File: rtl/pal_byte_writer.sv
module pal_byte_writer
  import pal_wr_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ptr_we,
  input  logic [IDX_W-1:0]     ptr_data,
  input  logic                 byte_we,
  input  logic [BYTE_W-1:0]    byte_data,
  output logic                 pal_we,
  output logic [IDX_W-1:0]     pal_idx,
  output logic [COLOR_W-1:0]   pal_val
);
  logic [1:0]       rst_sync;
  logic             rst_int_n;
  logic             phase_hi;
  logic             lo_cap;
  logic             hi_commit;
  logic [IDX_W-1:0] cur_idx;
  color_t           val_s;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync <= 2'b00;
    end else begin
      rst_sync <= {rst_sync[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync[1];

  pal_phase_ctl u_phase (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .ptr_we    (ptr_we),
    .byte_we   (byte_we),
    .phase_hi  (phase_hi),
    .lo_cap    (lo_cap),
    .hi_commit (hi_commit)
  );

  pal_idx_ctr #(.IDX_W(IDX_W)) u_idx (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load     (ptr_we),
    .load_val (ptr_data),
    .step     (hi_commit),
    .idx      (cur_idx)
  );

  pal_commit_reg #(.IDX_W(IDX_W)) u_commit (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .lo_cap    (lo_cap),
    .hi_commit (hi_commit),
    .byte_data (byte_data),
    .cur_idx   (cur_idx),
    .pal_we    (pal_we),
    .pal_idx   (pal_idx),
    .pal_val   (val_s)
  );

  assign pal_val = val_s;
endmodule

// File: rtl/pal_byte_writer_chk.sv
module pal_byte_writer_chk
  import pal_wr_pkg::*;
(
  input logic               clk,
  input logic               rst_int_n,
  input logic               ptr_we,
  input logic [IDX_W-1:0]   ptr_data,
  input logic               byte_we,
  input logic [BYTE_W-1:0]  byte_data,
  input logic               pal_we,
  input logic [IDX_W-1:0]   pal_idx,
  input logic [COLOR_W-1:0] pal_val,
  input logic [IDX_W-1:0]   cur_idx,
  input logic               phase_hi
);
  // R2
  lo_no_commit_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (byte_we && !ptr_we && !phase_hi) |=> (!pal_we && phase_hi));

  // R3
  commit_src_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    pal_we |-> $past(byte_we && !ptr_we && phase_hi));

  // R3
  commit_idx_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (byte_we && !ptr_we && phase_hi) |=> (pal_we && pal_idx == $past(cur_idx)));

  // R4
  hi_mask_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (byte_we && !ptr_we && phase_hi) |=>
      (pal_val[COLOR_W-1:BYTE_W] == $past(byte_data[HI_W-1:0])));

  // R5
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (byte_we && !ptr_we && phase_hi) |=> (cur_idx == IDX_W'($past(cur_idx) + IDX_W'(1))));

  // R6
  ptr_load_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    ptr_we |=> (cur_idx == $past(ptr_data) && !phase_hi));

  // R7
  same_cycle_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (ptr_we && byte_we) |=> !pal_we);

  // R8
  we_pulse_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    pal_we |=> !pal_we);
endmodule

bind pal_byte_writer pal_byte_writer_chk u_chk (
  .clk       (clk),
  .rst_int_n (rst_int_n),
  .ptr_we    (ptr_we),
  .ptr_data  (ptr_data),
  .byte_we   (byte_we),
  .byte_data (byte_data),
  .pal_we    (pal_we),
  .pal_idx   (pal_idx),
  .pal_val   (pal_val),
  .cur_idx   (cur_idx),
  .phase_hi  (phase_hi)
);

// File: tb/tb_pal_byte_writer.sv
module tb_pal_byte_writer;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [7:0]  idx;
    logic [14:0] val;
    string       tag;
  } exp_t;

  logic        clk;
  logic        rst_n;
  logic        ptr_we;
  logic [7:0]  ptr_data;
  logic        byte_we;
  logic [7:0]  byte_data;
  logic        pal_we;
  logic [7:0]  pal_idx;
  logic [14:0] pal_val;

  exp_t       exp_q[$];
  int         n_chk;
  int         n_fail;
  logic [7:0] m_idx;
  logic       m_hi;
  logic [7:0] m_lo;
  logic       prev_we;
  logic       done;

  pal_byte_writer dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .ptr_we    (ptr_we),
    .ptr_data  (ptr_data),
    .byte_we   (byte_we),
    .byte_data (byte_data),
    .pal_we    (pal_we),
    .pal_idx   (pal_idx),
    .pal_val   (pal_val)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  // Drivers: called at a negedge, hold the strobe for one cycle.
  task automatic load_ptr(input logic [7:0] v);
    ptr_we = 1'b1; ptr_data = v;
    m_idx = v; m_hi = 1'b0;
    @(negedge clk);
    ptr_we = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, input string tag);
    exp_t e;
    byte_we = 1'b1; byte_data = b;
    if (!m_hi) begin
      m_lo = b; m_hi = 1'b1;
    end else begin
      e.idx = m_idx; e.val = {b[6:0], m_lo}; e.tag = tag;
      exp_q.push_back(e);
      m_idx = m_idx + 8'd1; m_hi = 1'b0;
    end
    @(negedge clk);
    byte_we = 1'b0;
  endtask

  task automatic load_and_byte(input logic [7:0] v, input logic [7:0] b);
    ptr_we = 1'b1; ptr_data = v; byte_we = 1'b1; byte_data = b;
    m_idx = v; m_hi = 1'b0;
    @(negedge clk);
    ptr_we = 1'b0; byte_we = 1'b0;
  endtask

  task automatic send_colour(input logic [4:0] r, input logic [4:0] g, input logic [4:0] bl,
                             input string tag);
    logic [14:0] c;
    c = {bl, g, r};
    send_byte(c[7:0], tag);
    send_byte({1'b0, c[14:8]}, tag);
  endtask

  // Monitor: compares every storage write against the scoreboard.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (pal_we) begin
        check(!prev_we, "R8", "write enable longer than one cycle", 32'(prev_we), 32'd0);
        if (exp_q.size() == 0) begin
          check(1'b0, "R7", "unexpected storage write at entry", 32'(pal_idx), 32'd0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(pal_idx == e.idx, e.tag, "entry", 32'(pal_idx), 32'(e.idx));
          check(pal_val == e.val, e.tag, "colour", 32'(pal_val), 32'(e.val));
        end
      end
      prev_we = pal_we;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    n_chk = 0; n_fail = 0; done = 1'b0; prev_we = 1'b0;
    m_idx = 8'd0; m_hi = 1'b0; m_lo = 8'd0;
    rst_n = 1'b0; ptr_we = 1'b0; ptr_data = 8'd0; byte_we = 1'b0; byte_data = 8'd0;
    repeat (3) @(negedge clk);
    // R1: outputs cleared by reset
    check(pal_we == 1'b0, "R1", "write enable in reset", 32'(pal_we), 32'd0);
    check(pal_idx == 8'd0, "R1", "entry in reset", 32'(pal_idx), 32'd0);
    check(pal_val == 15'd0, "R1", "colour in reset", 32'(pal_val), 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: pair with no pointer load lands at entry 0
    send_byte(8'h1F, "R1");
    send_byte(8'h7C, "R1");
    @(negedge clk);

    // R2 / R3: low byte alone gives no write; pair commits with channel layout
    load_ptr(8'h10);
    send_byte(8'h34, "R2");
    check(pal_we == 1'b0, "R2", "write after low byte", 32'(pal_we), 32'd0);
    send_byte(8'h12, "R3");
    @(negedge clk);
    load_ptr(8'h11);
    send_colour(5'd3, 5'd17, 5'd30, "R3");
    @(negedge clk);

    // R4: top bit of the high byte discarded
    load_ptr(8'h20);
    send_byte(8'hFF, "R4");
    send_byte(8'hFF, "R4");
    send_byte(8'h00, "R4");
    send_byte(8'h80, "R4");

    // R5 / R8: back-to-back pairs fill consecutive entries, then wrap
    load_ptr(8'h30);
    for (int i = 0; i < 3; i++) begin
      send_byte(8'(8'hA0 + i), "R8");
      send_byte(8'(8'h50 + i), "R8");
    end
    load_ptr(8'hFE);
    for (int i = 0; i < 3; i++) begin
      send_byte(8'(8'h10 * i), "R5");
      send_byte(8'(8'h21 + i), "R5");
    end
    @(negedge clk);

    // R6: pointer load discards a staged low byte
    load_ptr(8'h40);
    send_byte(8'hAA, "R6");
    load_ptr(8'h41);
    send_byte(8'h11, "R6");
    send_byte(8'h22, "R6");
    @(negedge clk);

    // R7: same-cycle load and byte, with a low byte staged, then in low phase
    load_ptr(8'h50);
    send_byte(8'h55, "R7");
    load_and_byte(8'h60, 8'h99);
    check(pal_we == 1'b0, "R7", "write after same-cycle load", 32'(pal_we), 32'd0);
    send_byte(8'h01, "R7");
    send_byte(8'h02, "R7");
    load_and_byte(8'h70, 8'h33);
    send_byte(8'h44, "R7");
    check(pal_we == 1'b0, "R7", "write after byte following load", 32'(pal_we), 32'd0);
    send_byte(8'h05, "R7");

    repeat (4) @(negedge clk);
    done = 1'b1;
    check(exp_q.size() == 0, "R3", "pending expected writes", 32'(exp_q.size()), 32'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule